// File: doc/BRIEF.md
# Stereo Audio Sample Buffer with Word Register Access

This block sits between a processor's 32-bit word bus and a stereo audio codec link. Four sample FIFOs hold the data. Two are capture FIFOs, left and right, that the codec side fills through valid/ready streams and the processor drains by reading data registers. The other two are playback FIFOs that the processor fills by writing data registers and the codec side drains through valid/ready streams. The serial framing of the codec link is outside this block.

Software sees four word registers, selected by a 2-bit word index where byte offset = 4 × index:

- **Control** (index 0) holds the interrupt enables and the clear bits, and reports the two pending flags.
- **Level status** (index 1) is read-only. It packs the fill level of each capture FIFO and the free space of each playback FIFO into four byte fields.
- **Left** (index 2) and **Right** (index 3) are the data registers. Reading one pops the matching capture FIFO. Writing one pushes the matching playback FIFO.

A watermark interrupt is raised when capture data piles up or playback data runs low. Holding a clear bit keeps the matching pair of FIFOs empty.

Only one bus operation is issued per cycle. A write takes effect at the clock edge where `bus_wr` is sampled high. A read is sampled at an edge, and `bus_rdata` carries the result from the following cycle until the next read. On the stream ports a sample moves only in a cycle where valid and ready are both high. A capture port deasserts ready when its FIFO is full or its clear bit is held, and the source must then keep its sample. A playback port deasserts valid when its FIFO is empty or its clear bit is held.

Top module: `stereo_audio_port`

## Requirements
- R1: Each FIFO holds at most DEPTH (default 128) words of 32 bits. A capture port's ready is high exactly when its FIFO holds fewer than DEPTH words and the capture clear bit is 0.
- R2: A read of Control returns the interrupt enables and clear bits in these positions: read enable in bit 0, write enable in bit 1, capture clear in bit 2, playback clear in bit 3. It returns the read pending flag in bit 8 and the write pending flag in bit 9. All other bits read 0.
- R3: The read pending flag is 1 exactly when the read enable is 1 and at least one capture FIFO holds 3·DEPTH/4 words or more (96 by default).
- R4: The write pending flag is 1 exactly when the write enable is 1 and at least one playback FIFO holds fewer than DEPTH/4 words (32 by default).
- R5: Writing 1 to the capture clear bit empties both capture FIFOs at that write's edge. They stay empty, with both capture ready signals low, for as long as the bit stays 1.
- R6: Writing 1 to the playback clear bit empties both playback FIFOs at that write's edge. They stay empty, with both playback valid signals low, for as long as the bit stays 1.
- R7: A read of the level status register returns four byte fields. Bits [7:0] hold the right capture level and bits [15:8] the left capture level. Bits [23:16] hold the right playback free space and bits [31:24] the left playback free space. After reset it reads 0x80800000.
- R8: A read of Left or Right from a non-empty capture FIFO returns its oldest word and removes it. Samples come out in arrival order.
- R9: A write of Left or Right to a playback FIFO with room appends the word. The codec side receives the words in write order on the matching out port.
- R10: A read of Left or Right from an empty capture FIFO returns 0 and changes no level. A write to a full playback FIFO is dropped.
- R11: The irq output is the OR of the read and write pending flags.
- R12: A playback port's valid is high exactly when its FIFO is non-empty and the playback clear bit is 0. Its data is then the oldest word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_word | input | 2 | Register word index (0 Control, 1 level status, 2 Left, 3 Right) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read result, valid the cycle after the read |
| in_l_valid | input | 1 | Left capture sample valid |
| in_l_ready | output | 1 | Left capture FIFO can accept |
| in_l_data | input | 32 | Left capture sample |
| in_r_valid | input | 1 | Right capture sample valid |
| in_r_ready | output | 1 | Right capture FIFO can accept |
| in_r_data | input | 32 | Right capture sample |
| out_l_valid | output | 1 | Left playback sample available |
| out_l_ready | input | 1 | Codec takes left playback sample |
| out_l_data | output | 32 | Left playback sample |
| out_r_valid | output | 1 | Right playback sample available |
| out_r_ready | input | 1 | Codec takes right playback sample |
| out_r_data | output | 32 | Right playback sample |
| irq | output | 1 | Watermark interrupt |

## Verification
A capture FIFO can be pushed by its codec stream and popped by a register read in the same cycle, and a playback FIFO can be pushed by a register write and drained by its codec stream in the same cycle. A clear write can also land in the same cycle as a stream handshake. Random phases with different push and pop rates make these collisions frequent, including at the full and empty boundaries. A queue model in the bench judges every collision: it takes accept decisions from the pre-edge levels and lets a clear override both the push and the pop. The levels sweep through the 96 and 32 watermarks, and the irq output and Control readback are compared against the model at each step.

// File: rtl/audport_pkg.sv
package audport_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_SPACE = 2'd1,
    SEL_LEFT  = 2'd2,
    SEL_RIGHT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic cw;  // playback clear
    logic cr;  // capture clear
    logic we;  // write watermark enable
    logic re;  // read watermark enable
  } ctrl_t;

  localparam int BIT_RE = 0;
  localparam int BIT_WE = 1;
  localparam int BIT_CR = 2;
  localparam int BIT_CW = 3;

  function automatic logic [7:0] fld8(input logic [31:0] v);
    return v[7:0];
  endfunction

endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (level == DEPTH_L);
  assign empty   = (level == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/watermark_flags.sv
module watermark_flags #(
  parameter int DEPTH = 128,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic          re,
  input  logic          we,
  input  logic [LW-1:0] cap_lvl_l,
  input  logic [LW-1:0] cap_lvl_r,
  input  logic [LW-1:0] play_lvl_l,
  input  logic [LW-1:0] play_lvl_r,
  output logic          ri,
  output logic          wi
);

  localparam logic [LW-1:0] HI_MARK = LW'((DEPTH * 3) / 4);
  localparam logic [LW-1:0] LO_MARK = LW'(DEPTH / 4);

  logic cap_high, play_low;

  always_comb begin
    cap_high = (cap_lvl_l >= HI_MARK) || (cap_lvl_r >= HI_MARK);
    play_low = (play_lvl_l < LO_MARK) || (play_lvl_r < LO_MARK);
    ri       = re && cap_high;
    wi       = we && play_low;
  end

endmodule

// File: rtl/stereo_audio_port.sv
module stereo_audio_port
  import audport_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 32,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_word,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          in_l_valid,
  output logic          in_l_ready,
  input  logic [DW-1:0] in_l_data,
  input  logic          in_r_valid,
  output logic          in_r_ready,
  input  logic [DW-1:0] in_r_data,
  output logic          out_l_valid,
  input  logic          out_l_ready,
  output logic [DW-1:0] out_l_data,
  output logic          out_r_valid,
  input  logic          out_r_ready,
  output logic [DW-1:0] out_r_data,
  output logic          irq
);

  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  reg_sel_e sel;
  ctrl_t    ctrl_q;
  logic     ctrl_wr, clr_in, clr_out;
  logic     ri, wi;

  logic [1:0]    in_valid, in_ready, in_push, in_pop, in_full, in_empty;
  logic [1:0]    out_valid, out_ready, out_push, out_pop, out_full, out_empty;
  logic [DW-1:0] in_data  [2];
  logic [DW-1:0] in_head  [2];
  logic [DW-1:0] out_head [2];
  logic [LW-1:0] in_lvl   [2];
  logic [LW-1:0] out_lvl  [2];
  logic [LW-1:0] out_free [2];

  assign sel     = reg_sel_e'(bus_word);
  assign ctrl_wr = bus_wr && (sel == SEL_CTRL);
  assign clr_in  = ctrl_q.cr || (ctrl_wr && bus_wdata[BIT_CR]);
  assign clr_out = ctrl_q.cw || (ctrl_wr && bus_wdata[BIT_CW]);

  assign in_valid   = {in_r_valid, in_l_valid};
  assign in_data[0] = in_l_data;
  assign in_data[1] = in_r_data;
  assign out_ready  = {out_r_ready, out_l_ready};

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    localparam reg_sel_e MY_SEL = (ch == 0) ? SEL_LEFT : SEL_RIGHT;

    assign in_ready[ch]  = !in_full[ch] && !ctrl_q.cr;
    assign in_push[ch]   = in_valid[ch] && in_ready[ch];
    assign in_pop[ch]    = bus_rd && (sel == MY_SEL);

    assign out_valid[ch] = !out_empty[ch] && !ctrl_q.cw;
    assign out_pop[ch]   = out_valid[ch] && out_ready[ch];
    assign out_push[ch]  = bus_wr && (sel == MY_SEL);
    assign out_free[ch]  = DEPTH_L - out_lvl[ch];

    sample_fifo #(.DEPTH(DEPTH), .DW(DW)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr_in),
      .push      (in_push[ch]),
      .push_data (in_data[ch]),
      .pop       (in_pop[ch]),
      .head      (in_head[ch]),
      .level     (in_lvl[ch]),
      .full      (in_full[ch]),
      .empty     (in_empty[ch])
    );

    sample_fifo #(.DEPTH(DEPTH), .DW(DW)) u_play (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr_out),
      .push      (out_push[ch]),
      .push_data (bus_wdata[DW-1:0]),
      .pop       (out_pop[ch]),
      .head      (out_head[ch]),
      .level     (out_lvl[ch]),
      .full      (out_full[ch]),
      .empty     (out_empty[ch])
    );
  end

  assign in_l_ready  = in_ready[0];
  assign in_r_ready  = in_ready[1];
  assign out_l_valid = out_valid[0];
  assign out_r_valid = out_valid[1];
  assign out_l_data  = out_head[0];
  assign out_r_data  = out_head[1];

  watermark_flags #(.DEPTH(DEPTH)) u_marks (
    .re         (ctrl_q.re),
    .we         (ctrl_q.we),
    .cap_lvl_l  (in_lvl[0]),
    .cap_lvl_r  (in_lvl[1]),
    .play_lvl_l (out_lvl[0]),
    .play_lvl_r (out_lvl[1]),
    .ri         (ri),
    .wi         (wi)
  );

  assign irq = ri || wi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_t'(bus_wdata[3:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (sel)
        SEL_CTRL:  bus_rdata <= {22'd0, wi, ri, 4'd0, ctrl_q};
        SEL_SPACE: bus_rdata <= {fld8(32'(out_free[0])), fld8(32'(out_free[1])),
                                 fld8(32'(in_lvl[0])),   fld8(32'(in_lvl[1]))};
        SEL_LEFT:  bus_rdata <= in_empty[0] ? '0 : 32'(in_head[0]);
        default:   bus_rdata <= in_empty[1] ? '0 : 32'(in_head[1]);
      endcase
    end
  end

endmodule

// File: rtl/audport_chk.sv
module audport_chk #(
  parameter int DEPTH = 128,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    bus_word,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [31:0]   bus_rdata,
  input logic          in_l_valid,
  input logic          in_l_ready,
  input logic          in_r_ready,
  input logic          out_l_valid,
  input logic          out_r_valid,
  input logic          irq,
  input logic          cr,
  input logic          cw,
  input logic          re,
  input logic          we,
  input logic          clr_in,
  input logic [LW-1:0] in_lvl_l,
  input logic [LW-1:0] in_lvl_r,
  input logic [LW-1:0] out_lvl_l
);

  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);
  localparam logic [LW-1:0] HI_L    = LW'((DEPTH * 3) / 4);
  localparam logic [LW-1:0] LO_L    = LW'(DEPTH / 4);

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lvl_l <= DEPTH_L) && (in_lvl_r <= DEPTH_L));

  assert_full_blocks_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lvl_l == DEPTH_L) |-> !in_l_ready);

  assert_read_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (re && (in_lvl_l >= HI_L)) |-> irq);

  assert_write_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (out_lvl_l < LO_L)) |-> irq);

  assert_cap_clear_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cr |-> (!in_l_ready && !in_r_ready));

  assert_cap_clear_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cr |=> (in_lvl_l == '0) && (in_lvl_r == '0));

  assert_play_clear_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cw |-> (!out_l_valid && !out_r_valid));

  assert_pop_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && (bus_word == 2'd2) && (in_lvl_l != '0) && !clr_in &&
     !(in_l_valid && in_l_ready)) |=> (in_lvl_l == $past(in_lvl_l) - LW'(1)));

  assert_empty_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_word == 2'd2) && (in_lvl_l == '0)) |=> (bus_rdata == 32'd0));

  assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (re || we));

endmodule

bind stereo_audio_port audport_chk #(.DEPTH(DEPTH)) u_audport_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_word    (bus_word),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .in_l_valid  (in_l_valid),
  .in_l_ready  (in_l_ready),
  .in_r_ready  (in_r_ready),
  .out_l_valid (out_l_valid),
  .out_r_valid (out_r_valid),
  .irq         (irq),
  .cr          (ctrl_q.cr),
  .cw          (ctrl_q.cw),
  .re          (ctrl_q.re),
  .we          (ctrl_q.we),
  .clr_in      (clr_in),
  .in_lvl_l    (in_lvl[0]),
  .in_lvl_r    (in_lvl[1]),
  .out_lvl_l   (out_lvl[0])
);

// File: tb/test_stereo_audio_port.sv
module test_stereo_audio_port;

  localparam int DEPTH = 128;
  localparam int HI    = 96;
  localparam int LO    = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_word = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        in_l_valid = 1'b0, in_r_valid = 1'b0, in_l_ready, in_r_ready;
  logic [31:0] in_l_data = '0, in_r_data = '0;
  logic        out_l_valid, out_r_valid;
  logic        out_l_ready = 1'b0, out_r_ready = 1'b0;
  logic [31:0] out_l_data, out_r_data;
  logic        irq;

  always #4 clk = ~clk;

  stereo_audio_port i_stereo_audio_port (
    .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_l_valid(in_l_valid), .in_l_ready(in_l_ready), .in_l_data(in_l_data),
    .in_r_valid(in_r_valid), .in_r_ready(in_r_ready), .in_r_data(in_r_data),
    .out_l_valid(out_l_valid), .out_l_ready(out_l_ready), .out_l_data(out_l_data),
    .out_r_valid(out_r_valid), .out_r_ready(out_r_ready), .out_r_data(out_r_data),
    .irq(irq)
  );

  logic [31:0] q_il[$], q_ir[$], q_ol[$], q_or[$];
  logic        m_re = 0, m_we = 0, m_cr = 0, m_cw = 0;
  logic        exp_pending = 0;
  logic [31:0] exp_rd = '0;
  string       exp_tag = "";
  int          n_vec = 0, n_bad = 0;
  bit          done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic ri_m();
    return m_re && (q_il.size() >= HI || q_ir.size() >= HI);
  endfunction

  function automatic logic wi_m();
    return m_we && (q_ol.size() < LO || q_or.size() < LO);
  endfunction

  task automatic compare();
    chk(m_cr ? "R5 in_l_ready" : "R1 in_l_ready", 32'(in_l_ready), 32'(q_il.size() < DEPTH && !m_cr));
    chk(m_cr ? "R5 in_r_ready" : "R1 in_r_ready", 32'(in_r_ready), 32'(q_ir.size() < DEPTH && !m_cr));
    chk(m_cw ? "R6 out_l_valid" : "R12 out_l_valid", 32'(out_l_valid), 32'(q_ol.size() > 0 && !m_cw));
    chk(m_cw ? "R6 out_r_valid" : "R12 out_r_valid", 32'(out_r_valid), 32'(q_or.size() > 0 && !m_cw));
    if (q_ol.size() > 0 && !m_cw) chk("R9 out_l_data", out_l_data, q_ol[0]);
    if (q_or.size() > 0 && !m_cw) chk("R9 out_r_data", out_r_data, q_or[0]);
    chk("R11 irq", 32'(irq), 32'(ri_m() || wi_m()));
    if (exp_pending) chk(exp_tag, bus_rdata, exp_rd);
  endtask

  task automatic model_update();
    logic clr_i, clr_o, pu_l, pu_r, po_l, po_r, opu_l, opu_r, opo_l, opo_r;
    exp_pending = bus_rd;
    if (bus_rd) begin
      case (bus_word)
        2'd0: begin
          exp_rd  = {22'd0, wi_m(), ri_m(), 4'd0, m_cw, m_cr, m_we, m_re};
          exp_tag = "R2 R3 R4 control readback";
        end
        2'd1: begin
          exp_rd  = {8'(DEPTH - q_ol.size()), 8'(DEPTH - q_or.size()),
                     8'(q_il.size()), 8'(q_ir.size())};
          exp_tag = "R7 level status";
        end
        2'd2: begin
          exp_rd  = (q_il.size() > 0) ? q_il[0] : 32'd0;
          exp_tag = (q_il.size() > 0) ? "R8 left pop" : "R10 left empty read";
        end
        default: begin
          exp_rd  = (q_ir.size() > 0) ? q_ir[0] : 32'd0;
          exp_tag = (q_ir.size() > 0) ? "R8 right pop" : "R10 right empty read";
        end
      endcase
    end
    clr_i = m_cr || (bus_wr && bus_word == 2'd0 && bus_wdata[2]);
    clr_o = m_cw || (bus_wr && bus_word == 2'd0 && bus_wdata[3]);
    pu_l  = in_l_valid && q_il.size() < DEPTH && !m_cr;
    pu_r  = in_r_valid && q_ir.size() < DEPTH && !m_cr;
    po_l  = bus_rd && bus_word == 2'd2 && q_il.size() > 0;
    po_r  = bus_rd && bus_word == 2'd3 && q_ir.size() > 0;
    opo_l = out_l_ready && q_ol.size() > 0 && !m_cw;
    opo_r = out_r_ready && q_or.size() > 0 && !m_cw;
    opu_l = bus_wr && bus_word == 2'd2 && q_ol.size() < DEPTH;
    opu_r = bus_wr && bus_word == 2'd3 && q_or.size() < DEPTH;
    if (clr_i) begin
      q_il.delete(); q_ir.delete();
    end else begin
      if (po_l) void'(q_il.pop_front());
      if (po_r) void'(q_ir.pop_front());
      if (pu_l) q_il.push_back(in_l_data);
      if (pu_r) q_ir.push_back(in_r_data);
    end
    if (clr_o) begin
      q_ol.delete(); q_or.delete();
    end else begin
      if (opo_l) void'(q_ol.pop_front());
      if (opo_r) void'(q_or.pop_front());
      if (opu_l) q_ol.push_back(bus_wdata);
      if (opu_r) q_or.push_back(bus_wdata);
    end
    if (bus_wr && bus_word == 2'd0) {m_cw, m_cr, m_we, m_re} = bus_wdata[3:0];
  endtask

  task automatic tick();
    #1;
    compare();
    model_update();
    @(negedge clk);
  endtask

  task automatic bus_idle();
    bus_rd = 0; bus_wr = 0; bus_word = 2'd0; bus_wdata = '0;
  endtask

  task automatic bus_op(input bit wr, input logic [1:0] w, input logic [31:0] d);
    bus_rd = !wr; bus_wr = wr; bus_word = w; bus_wdata = d;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    int kind, p_in, p_out, p_rd, p_wr, r;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // directed: reset state readbacks and an empty pop
    bus_op(0, 2'd1, '0); tick();   // R7 reset value 0x80800000
    bus_op(0, 2'd0, '0); tick();   // R2 control reset
    bus_op(0, 2'd2, '0); tick();   // R10 empty left read
    bus_op(0, 2'd3, '0); tick();   // R10 empty right read
    bus_op(1, 2'd0, 32'h3); tick();// enable both watermarks (R4 active while empty)
    bus_op(0, 2'd0, '0); tick();
    bus_idle();
    for (int ph = 0; ph < 36; ph++) begin
      kind = ph % 6;
      if (kind == 4) bus_op(1, 2'd0, {28'd0, 2'($urandom_range(1, 3)), 2'b11});
      else           bus_op(1, 2'd0, {28'd0, 2'b00, 2'(($urandom % 4 == 0) ? $urandom : 3)});
      in_l_valid = 0; in_r_valid = 0; out_l_ready = 0; out_r_ready = 0;
      tick();
      case (kind)
        0: begin p_in = 90; p_out = 50; p_rd = 10; p_wr = 40; end
        1: begin p_in = 15; p_out = 50; p_rd = 70; p_wr = 10; end
        2: begin p_in = 50; p_out = 10; p_rd = 10; p_wr = 70; end
        3: begin p_in = 50; p_out = 90; p_rd = 40; p_wr = 5;  end
        4: begin p_in = 50; p_out = 50; p_rd = 30; p_wr = 30; end
        default: begin p_in = 50; p_out = 50; p_rd = 30; p_wr = 30; end
      endcase
      for (int c = 0; c < 250; c++) begin
        in_l_valid  = ($urandom % 100) < p_in;
        in_r_valid  = ($urandom % 100) < p_in;
        in_l_data   = $urandom;
        in_r_data   = $urandom;
        out_l_ready = ($urandom % 100) < p_out;
        out_r_ready = ($urandom % 100) < p_out;
        r = $urandom % 100;
        if (r < p_rd)             bus_op(0, 2'(2 + ($urandom % 2)), '0);
        else if (r < p_rd + p_wr) bus_op(1, 2'(2 + ($urandom % 2)), $urandom);
        else if (r < p_rd + p_wr + 8) bus_op(0, 2'($urandom % 2), '0);
        else                      bus_idle();
        tick();
      end
    end
    bus_op(0, 2'd1, '0); tick();
    bus_idle(); tick();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule